// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This unit turns a 16-bit offset into a 20-bit physical address. It keeps four 16-bit segment bases: code, data, stack and extra. For each request it picks one base, multiplies it by 16 and adds the offset. Each segment therefore opens a 64 KB window whose start lies on a 16-byte boundary. The sum is truncated to 20 bits, which gives a 1 MB space that wraps at the top.

The base is picked from the kind of access, so the requester does not have to name a segment:

- an instruction fetch uses the code base;
- a stack access uses the stack base;
- an ordinary data access uses the data base;
- a string destination uses the extra base.

A requester can replace that choice with an override select. The override has no effect on string destinations. The address, a valid flag and the segment that was used are registered and appear one clock after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: For a request with `req_valid`=1, `addr_out` on the next clock edge is (chosen base × 16 + `req_offset`) mod 2^20. For example, base A000h with offset 5F00h gives A5F00h.
- R2: `addr_valid` is 1 in the cycle after a cycle with `req_valid`=1, and 0 in the cycle after a cycle with `req_valid`=0.
- R3: With `ovr_valid`=0, the `req_class` codes select these bases: 0 (fetch) selects code, 1 (stack) selects stack, 2 (data) selects data, 3 (string destination) selects extra. The segment select codes are 0 extra, 1 code, 2 stack, 3 data. The chosen select code appears on `seg_used` one cycle after the request.
- R4: With `ovr_valid`=1 and `req_class` other than 3, `ovr_sel` replaces the default base. With `req_class`=3 the override is ignored and the extra base is used.
- R5: A sum above FFFFFh wraps modulo 2^20 and has no carry out. For example, base FFFFh with offset FFFFh gives 0FFEFh.
- R6: With `seg_wr_en`=1, the base addressed by `seg_wr_sel` loads `seg_wr_data` at the clock edge. A request made in the same cycle as the write still uses the old value. Later requests use the new value.
- R7: After reset the code base is FFFFh and the other three bases are 0. `addr_out` and `seg_used` are 0, and `addr_valid` is 0.
- R8: In a cycle with `req_valid`=0, `addr_out` and `seg_used` keep their previous values on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Segment base write strobe |
| seg_wr_sel | input | 2 | Base to write (0 extra, 1 code, 2 stack, 3 data) |
| seg_wr_data | input | 16 | New base value |
| req_valid | input | 1 | Address request this cycle |
| req_class | input | 2 | Access kind (0 fetch, 1 stack, 2 data, 3 string destination) |
| req_offset | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Use `ovr_sel` instead of the default base |
| ovr_sel | input | 2 | Override base select |
| addr_out | output | 20 | Registered physical address |
| addr_valid | output | 1 | `addr_out` is for the previous cycle's request |
| seg_used | output | 2 | Select code of the base used by that request |

## Verification
Every result of this block is due one clock edge after the request that causes it: the address, the valid flag and the used-segment code. A base write changes nothing that can be seen until a request made in a later cycle. The bench drives inputs on the falling edge and samples the outputs just after the next rising edge. At that point it compares them with values it computed from its own model of the bases, as the model stood before that cycle's write. The model is updated only after the comparison, so the same-cycle write rule is checked with exact timing.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W    = 16,
  parameter int OFS_W    = 16,
  parameter int SHIFT    = 4,
  parameter int ADDR_W   = 20,
  parameter int SEL_W    = 2,
  parameter logic [SEG_W-1:0] CS_RESET = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_wr_en,
  input  logic [SEL_W-1:0]  seg_wr_sel,
  input  logic [SEG_W-1:0]  seg_wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_class,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic              ovr_valid,
  input  logic [SEL_W-1:0]  ovr_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid,
  output logic [SEL_W-1:0]  seg_used
);

  localparam int NSEG = 1 << SEL_W;
  localparam logic [SEL_W-1:0] SEL_ES = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_CS = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_SS = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_DS = SEL_W'(3);
  localparam logic [1:0] CLS_FETCH = 2'd0;
  localparam logic [1:0] CLS_STACK = 2'd1;
  localparam logic [1:0] CLS_DATA  = 2'd2;
  localparam logic [1:0] CLS_STRD  = 2'd3;

  logic [SEG_W-1:0]  seg_q [NSEG];
  logic [SEL_W-1:0]  dflt_sel, eff_sel;
  logic [ADDR_W-1:0] phys;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++)
        seg_q[i] <= (SEL_W'(i) == SEL_CS) ? CS_RESET : '0;
    end else if (seg_wr_en) begin
      seg_q[seg_wr_sel] <= seg_wr_data;
    end
  end

  always_comb begin
    case (req_class)
      CLS_FETCH: dflt_sel = SEL_CS;
      CLS_STACK: dflt_sel = SEL_SS;
      CLS_DATA:  dflt_sel = SEL_DS;
      default:   dflt_sel = SEL_ES;
    endcase
  end

  assign eff_sel = (ovr_valid && req_class != CLS_STRD) ? ovr_sel : dflt_sel;
  assign phys    = (ADDR_W'(seg_q[eff_sel]) << SHIFT) + ADDR_W'(req_offset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
      seg_used   <= '0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) begin
        addr_out <= phys;
        seg_used <= eff_sel;
      end
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid); // R2
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid); // R2
  AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ovr_valid && req_class == CLS_FETCH) |=> seg_used == SEL_CS); // R3
  AST_STACK_SS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ovr_valid && req_class == CLS_STACK) |=> seg_used == SEL_SS); // R3
  AST_DATA_DS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ovr_valid && req_class == CLS_DATA) |=> seg_used == SEL_DS); // R3
  AST_STRD_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == CLS_STRD) |=> seg_used == SEL_ES); // R4
  AST_OVR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ovr_valid && req_class != CLS_STRD) |=> seg_used == $past(ovr_sel)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(addr_out) && $stable(seg_used))); // R8

endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_class = '0;
  logic [15:0] req_offset = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [19:0] addr_out;
  logic        addr_valid;
  logic [1:0]  seg_used;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_seg [4];
  logic [19:0] last_addr;
  logic [1:0]  last_sel;

  always #4 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
    .seg_wr_data(seg_wr_data), .req_valid(req_valid), .req_class(req_class),
    .req_offset(req_offset), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
    .addr_out(addr_out), .addr_valid(addr_valid), .seg_used(seg_used));

  function automatic logic [1:0] exp_sel(input logic [1:0] cls, input logic ov, input logic [1:0] os);
    logic [1:0] d;
    case (cls)
      2'd0: d = 2'd1;
      2'd1: d = 2'd2;
      2'd2: d = 2'd3;
      default: d = 2'd0;
    endcase
    return (ov && cls != 2'd3) ? os : d;
  endfunction

  function automatic logic [19:0] exp_addr(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] w;
    w = {1'b0, s, 4'h0} + {5'h0, o};
    return w[19:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                      input logic rv, input logic [1:0] cls, input logic [15:0] off,
                      input logic ov, input logic [1:0] os, input string req);
    logic [1:0]  es;
    logic [19:0] ea;
    @(negedge clk);
    seg_wr_en = we; seg_wr_sel = ws; seg_wr_data = wd;
    req_valid = rv; req_class = cls; req_offset = off; ovr_valid = ov; ovr_sel = os;
    es = exp_sel(cls, ov, os);
    ea = exp_addr(m_seg[es], off);
    @(posedge clk);
    #1;
    check(req, {31'b0, addr_valid}, {31'b0, rv});
    if (rv) begin
      check(req, {12'b0, addr_out}, {12'b0, ea});
      check(req, {30'b0, seg_used}, {30'b0, es});
      last_addr = ea; last_sel = es;
    end else begin
      check(req, {12'b0, addr_out}, {12'b0, last_addr});
      check(req, {30'b0, seg_used}, {30'b0, last_sel});
    end
    if (we) m_seg[ws] = wd;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_seg[0] = 16'h0; m_seg[1] = 16'hFFFF; m_seg[2] = 16'h0; m_seg[3] = 16'h0;
    last_addr = '0; last_sel = '0;
    #20;
    check("R7 reset addr", {12'b0, addr_out}, 32'h0);
    check("R7 reset valid", {31'b0, addr_valid}, 32'h0);
    check("R7 reset seg_used", {30'b0, seg_used}, 32'h0);
    rst_n = 1'b1;
    // R7: reset bases seen through requests
    step(0, 0, 0, 1, 2'd0, 16'h0000, 0, 0, "R7 code base FFFF");
    step(0, 0, 0, 1, 2'd1, 16'h0010, 0, 0, "R7 stack base 0");
    // R6 then R1 worked example
    step(1, 2'd3, 16'hA000, 0, 0, 0, 0, 0, "R8 idle during write");
    step(0, 0, 0, 1, 2'd2, 16'h5F00, 0, 0, "R1 A000:5F00");
    check("R1 A5F00", {12'b0, addr_out}, 32'hA5F00);
    // R5 wrap
    step(1, 2'd1, 16'hFFFF, 0, 0, 0, 0, 0, "R8 idle");
    step(0, 0, 0, 1, 2'd0, 16'hFFFF, 0, 0, "R5 wrap");
    check("R5 0FFEF", {12'b0, addr_out}, 32'h0FFEF);
    // R6 same-cycle write uses old value
    step(1, 2'd2, 16'h1234, 1, 2'd1, 16'h0002, 0, 0, "R6 same-cycle old value");
    step(0, 0, 0, 1, 2'd1, 16'h0002, 0, 0, "R6 new value");
    // R3 defaults, R4 override and its exception
    step(1, 2'd0, 16'h4000, 0, 0, 0, 0, 0, "R8 idle");
    step(0, 0, 0, 1, 2'd3, 16'h0100, 0, 0, "R3 string dest extra");
    step(0, 0, 0, 1, 2'd3, 16'h0100, 1, 2'd3, "R4 override ignored on string dest");
    step(0, 0, 0, 1, 2'd2, 16'h0100, 1, 2'd0, "R4 override data to extra");
    step(0, 0, 0, 1, 2'd0, 16'h0100, 1, 2'd2, "R4 override fetch to stack");
    step(0, 0, 0, 0, 2'd1, 16'h7777, 1, 2'd1, "R8 hold R2 idle");
    for (int i = 0; i < 600; i++) begin
      step(1'($urandom % 4 == 0), 2'($urandom), 16'($urandom),
           1'($urandom % 5 != 0), 2'($urandom), 16'($urandom),
           1'($urandom % 3 == 0), 2'($urandom), "R1 R3 R4 R6 R8 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule